// File: doc/BRIEF.md
# Selectable Event Statistics Counter Bank

This block keeps six event counters for the datapath of a wireless transceiver. Each counter follows one of two event sources, and a bit of a shared select register picks which one. Some sources are raw one-cycle pulses from the PHY and the MAC, such as preamble detections, transmit start and end, gain changes and AGC lock. Others are qualified inside the block. One is a header strobe that carries a valid flag. Another is a decoded frame whose sender matched a programmed target, which was addressed to this station, which carried data and, for one of the counters, which passed its CRC. A further source is the rising crossing of the received signal strength above a programmed threshold.

Software uses a simple register port, with an index, write data and strobes for write and read. It programs three configuration registers: the sender-address target, the RSSI threshold and the source select. It reads the counters and clears any of them by writing to the counter's index. Counters hold at their maximum value and do not wrap.

Top module: `evstat_bank`

## Requirements
- R1: After reset every counter reads 0, and so do the configuration registers at indices 7, 9 and 19.
- R2: A write to index 7, 9 or 19 stores reg_wdata, and a read returns it. A read strobe at one rising edge puts the data on reg_rdata at that edge, where it holds until the next read. Any index that is not mapped reads 0.
- R3: With its select bit at 0, the counter at index 26 counts ev_short_pre and the counter at index 27 counts ev_long_pre. A counter adds exactly one for each cycle in which its selected source is high. The select bit of the counter at index 26+k is bit 4*k of register 19.
- R4: With its select bit at 1, the counters at indices 26 to 31 count, in that order: ev_tx_start, ev_tx_done, RSSI crossings, ev_gain_change, ev_agc_lock and ev_tx_need_ack.
- R5: With select 0, index 28 counts every ev_hdr_strobe. Index 29 counts only the ev_hdr_strobe cycles in which hdr_valid is also high, and hdr_valid alone has no effect.
- R6: With select 0, index 30 counts the cycles in which ev_decode_done, rx_to_self and rx_is_data are all high and rx_sender_lo equals register 7. This count does not depend on crc_ok. The target covers the low 32 bits of the sender MAC address, so sender 6c:fd:b9:4c:b1:c1 matches the target 0xb94cb1c1.
- R7: With select 0, index 31 counts the same qualified frames as index 30, but only those that also have crc_ok high. crc_ok without ev_decode_done has no effect.
- R8: An RSSI crossing happens in the cycle where rssi is first strictly greater than the low RSSI_W bits of register 9. If rssi stays above the threshold, it counts only once. A value equal to the threshold is not above it.
- R9: A write of any data to a counter index sets that counter to 0, and the other counters are unaffected. If the write and a selected event happen in the same cycle, the counter still ends at 0.
- R10: A counter that reaches 2^CNT_W-1 stays there while more events arrive, until it is cleared.
- R11: A source that is not selected leaves its counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_idx | input | IDX_W | Register index |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered on reg_rd |
| ev_short_pre | input | 1 | Short preamble detected pulse |
| ev_long_pre | input | 1 | Long preamble detected pulse |
| ev_tx_start | input | 1 | PHY transmit start pulse |
| ev_tx_done | input | 1 | PHY transmit done pulse |
| ev_hdr_strobe | input | 1 | Header decode strobe |
| hdr_valid | input | 1 | Header valid flag, sampled with ev_hdr_strobe |
| ev_gain_change | input | 1 | Gain change pulse |
| ev_agc_lock | input | 1 | AGC lock pulse |
| ev_tx_need_ack | input | 1 | Transmitted packet requiring acknowledgement |
| ev_decode_done | input | 1 | Frame decode finished, CRC good or bad |
| crc_ok | input | 1 | Frame CRC correct |
| rx_sender_lo | input | ADDR_CMP_W | Low bits of the received sender MAC address |
| rx_to_self | input | 1 | Destination address is this station |
| rx_is_data | input | 1 | Frame type is data |
| rssi | input | RSSI_W | Received signal strength, unsigned |

## Verification
An event that is high at a rising edge is added to the counter at that same edge. A read strobe raised at the following edge therefore already returns the new count. reg_rdata is registered, so each read result is due at the rising edge that samples reg_rd. Configuration writes take effect one edge after they are sampled. The bench drives every input on the falling edge. A driver task queues the expected value of each read, and a monitor compares reg_rdata on the falling edge after the edge that sampled the strobe. Event bursts always finish before the read that checks them is issued.

// File: rtl/evstat_pkg.sv
package evstat_pkg;

   // Register indices; the counter block is contiguous and ordered by source pair
   localparam int IDX_ADDR_TGT = 7;
   localparam int IDX_RSSI_TH  = 9;
   localparam int IDX_SRC_SEL  = 19;
   localparam int IDX_CNT_BASE = 26;
   localparam int NUM_CNT      = 6;
   // Distance between the select bits of neighbouring counters
   localparam int SEL_STRIDE   = 4;

   typedef logic [NUM_CNT-1:0] src_vec_t;

endpackage

// File: rtl/evstat_counter.sv
module evstat_counter #(
   parameter int CNT_W    = 32,
   parameter bit SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             inc,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_next;

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            cnt_next = cnt;
            if (inc && cnt != CNT_MAX) cnt_next = cnt + CNT_W'(1);
         end
      end else begin : g_wrap
         always_comb begin
            cnt_next = cnt;
            if (inc) cnt_next = cnt + CNT_W'(1);
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else          cnt <= cnt_next;
   end

   // R9: a clear wins over a coincident event
   a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> cnt == '0);

   // R3: one step per selected event below the cap
   a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && inc && cnt != CNT_MAX) |=> cnt == $past(cnt) + CNT_W'(1));

   // R11: no event, no change
   a_r11_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && !inc) |=> $stable(cnt));

   generate
      if (SATURATE) begin : g_sat_chk
         // R10: stays at the cap
         a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
            (!clr && cnt == CNT_MAX) |=> cnt == CNT_MAX);
      end
   endgenerate

endmodule

// File: rtl/evstat_qual.sv
module evstat_qual
   import evstat_pkg::*;
#(
   parameter int ADDR_CMP_W = 32,
   parameter int RSSI_W     = 11
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ev_short_pre,
   input  logic                  ev_long_pre,
   input  logic                  ev_tx_start,
   input  logic                  ev_tx_done,
   input  logic                  ev_hdr_strobe,
   input  logic                  hdr_valid,
   input  logic                  ev_gain_change,
   input  logic                  ev_agc_lock,
   input  logic                  ev_tx_need_ack,
   input  logic                  ev_decode_done,
   input  logic                  crc_ok,
   input  logic [ADDR_CMP_W-1:0] rx_sender_lo,
   input  logic                  rx_to_self,
   input  logic                  rx_is_data,
   input  logic [ADDR_CMP_W-1:0] addr_tgt,
   input  logic [RSSI_W-1:0]     rssi,
   input  logic [RSSI_W-1:0]     rssi_th,
   output src_vec_t              src_lo,
   output src_vec_t              src_hi
);

   logic above_now, above_q, rssi_rise;
   logic frame_hit;

   assign above_now = rssi > rssi_th;
   assign rssi_rise = above_now && !above_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) above_q <= 1'b0;
      else        above_q <= above_now;
   end

   assign frame_hit = ev_decode_done && rx_to_self && rx_is_data
                      && (rx_sender_lo == addr_tgt);

   // Bit k feeds the counter at index IDX_CNT_BASE + k
   assign src_lo = {frame_hit && crc_ok, frame_hit,
                    ev_hdr_strobe && hdr_valid, ev_hdr_strobe,
                    ev_long_pre, ev_short_pre};
   assign src_hi = {ev_tx_need_ack, ev_agc_lock, ev_gain_change,
                    rssi_rise, ev_tx_done, ev_tx_start};

   // R8: a crossing is never two cycles long
   a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      src_hi[2] |=> !src_hi[2]);

   // R7: a CRC-good qualified frame is also a qualified frame
   a_r7_subset: assert property (@(posedge clk) disable iff (!rst_n)
      src_lo[5] |-> src_lo[4]);

endmodule

// File: rtl/evstat_bank.sv
module evstat_bank
   import evstat_pkg::*;
#(
   parameter int IDX_W      = 6,
   parameter int DATA_W     = 32,
   parameter int CNT_W      = 32,
   parameter int ADDR_CMP_W = 32,
   parameter int RSSI_W     = 11,
   parameter bit SATURATE   = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_wr,
   input  logic                  reg_rd,
   input  logic [IDX_W-1:0]      reg_idx,
   input  logic [DATA_W-1:0]     reg_wdata,
   output logic [DATA_W-1:0]     reg_rdata,
   input  logic                  ev_short_pre,
   input  logic                  ev_long_pre,
   input  logic                  ev_tx_start,
   input  logic                  ev_tx_done,
   input  logic                  ev_hdr_strobe,
   input  logic                  hdr_valid,
   input  logic                  ev_gain_change,
   input  logic                  ev_agc_lock,
   input  logic                  ev_tx_need_ack,
   input  logic                  ev_decode_done,
   input  logic                  crc_ok,
   input  logic [ADDR_CMP_W-1:0] rx_sender_lo,
   input  logic                  rx_to_self,
   input  logic                  rx_is_data,
   input  logic [RSSI_W-1:0]     rssi
);

   localparam int IDX_SPAN = 1 << IDX_W;
   localparam int SEL_TOP  = SEL_STRIDE * (NUM_CNT - 1);

   // Elaboration-time parameter checks
   generate
      if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt_w
         $error("evstat_bank: CNT_W must be 1..DATA_W");
      end
      if (ADDR_CMP_W > DATA_W) begin : g_bad_addr_w
         $error("evstat_bank: ADDR_CMP_W exceeds DATA_W");
      end
      if (RSSI_W > DATA_W) begin : g_bad_rssi_w
         $error("evstat_bank: RSSI_W exceeds DATA_W");
      end
      if (IDX_SPAN < IDX_CNT_BASE + NUM_CNT) begin : g_bad_idx_w
         $error("evstat_bank: IDX_W too narrow for counter indices");
      end
      if (SEL_TOP >= DATA_W) begin : g_bad_sel
         $error("evstat_bank: select bits do not fit in DATA_W");
      end
   endgenerate

   logic [DATA_W-1:0] addr_tgt_q, rssi_th_q, src_sel_q;
   src_vec_t          src_lo, src_hi, cnt_inc, cnt_clr;
   logic [CNT_W-1:0]  cnt [NUM_CNT];
   logic [DATA_W-1:0] rd_mux;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_tgt_q <= '0;
         rssi_th_q  <= '0;
         src_sel_q  <= '0;
      end else if (reg_wr) begin
         if (reg_idx == IDX_W'(IDX_ADDR_TGT)) addr_tgt_q <= reg_wdata;
         if (reg_idx == IDX_W'(IDX_RSSI_TH))  rssi_th_q  <= reg_wdata;
         if (reg_idx == IDX_W'(IDX_SRC_SEL))  src_sel_q  <= reg_wdata;
      end
   end

   evstat_qual #(
      .ADDR_CMP_W (ADDR_CMP_W),
      .RSSI_W     (RSSI_W)
   ) u_qual (
      .clk            (clk),
      .rst_n          (rst_n),
      .ev_short_pre   (ev_short_pre),
      .ev_long_pre    (ev_long_pre),
      .ev_tx_start    (ev_tx_start),
      .ev_tx_done     (ev_tx_done),
      .ev_hdr_strobe  (ev_hdr_strobe),
      .hdr_valid      (hdr_valid),
      .ev_gain_change (ev_gain_change),
      .ev_agc_lock    (ev_agc_lock),
      .ev_tx_need_ack (ev_tx_need_ack),
      .ev_decode_done (ev_decode_done),
      .crc_ok         (crc_ok),
      .rx_sender_lo   (rx_sender_lo),
      .rx_to_self     (rx_to_self),
      .rx_is_data     (rx_is_data),
      .addr_tgt       (addr_tgt_q[ADDR_CMP_W-1:0]),
      .rssi           (rssi),
      .rssi_th        (rssi_th_q[RSSI_W-1:0]),
      .src_lo         (src_lo),
      .src_hi         (src_hi)
   );

   generate
      for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
         assign cnt_clr[g] = reg_wr && (reg_idx == IDX_W'(IDX_CNT_BASE + g));
         assign cnt_inc[g] = src_sel_q[SEL_STRIDE*g] ? src_hi[g] : src_lo[g];

         evstat_counter #(
            .CNT_W    (CNT_W),
            .SATURATE (SATURATE)
         ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr[g]),
            .inc   (cnt_inc[g]),
            .cnt   (cnt[g])
         );
      end
   endgenerate

   always_comb begin
      rd_mux = '0;
      if (reg_idx == IDX_W'(IDX_ADDR_TGT)) rd_mux = addr_tgt_q;
      if (reg_idx == IDX_W'(IDX_RSSI_TH))  rd_mux = rssi_th_q;
      if (reg_idx == IDX_W'(IDX_SRC_SEL))  rd_mux = src_sel_q;
      for (int i = 0; i < NUM_CNT; i++) begin
         if (reg_idx == IDX_W'(IDX_CNT_BASE + i)) rd_mux = DATA_W'(cnt[i]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_mux;
   end

   // R2: read data only moves on a read strobe
   a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));

endmodule

// File: tb/evstat_bank_test.sv
module evstat_bank_test;

   localparam int CW = 8;

   // Event vector bit positions (bench-local)
   localparam int E_SPRE = 0, E_LPRE = 1, E_TXS = 2, E_TXD = 3, E_HDR = 4,
                  E_HOK = 5, E_GAIN = 6, E_AGC = 7, E_ACK = 8, E_DEC = 9,
                  E_CRC = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [5:0]  reg_idx = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [10:0] ev = '0;
   logic [31:0] sender = '0;
   logic        to_self = 1'b0, is_data = 1'b0;
   logic [10:0] rssi = '0;

   int checks = 0;
   int bad = 0;
   int unsigned exp_q[$];
   string       tag_q[$];
   logic        rd_q = 1'b0;

   always #2 clk = ~clk;

   evstat_bank #(.CNT_W(CW)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_idx(reg_idx), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ev_short_pre(ev[E_SPRE]), .ev_long_pre(ev[E_LPRE]),
      .ev_tx_start(ev[E_TXS]), .ev_tx_done(ev[E_TXD]),
      .ev_hdr_strobe(ev[E_HDR]), .hdr_valid(ev[E_HOK]),
      .ev_gain_change(ev[E_GAIN]), .ev_agc_lock(ev[E_AGC]),
      .ev_tx_need_ack(ev[E_ACK]), .ev_decode_done(ev[E_DEC]),
      .crc_ok(ev[E_CRC]), .rx_sender_lo(sender), .rx_to_self(to_self),
      .rx_is_data(is_data), .rssi(rssi)
   );

   // Monitor: compares each read result on the falling edge after its strobe edge
   always @(posedge clk) rd_q <= reg_rd;

   always @(negedge clk) begin
      if (rd_q) begin
         checks++;
         if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL unexpected read result act=%0h exp=none", reg_rdata);
         end else begin
            int unsigned e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (reg_rdata !== e) begin
               bad++;
               $display("FAIL %s act=%0h exp=%0h", t, reg_rdata, e);
            end
         end
      end
   end

   task automatic wr(input int idx, input int unsigned d);
      reg_wr = 1'b1; reg_idx = 6'(idx); reg_wdata = d;
      @(posedge clk); @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int idx, input int unsigned e, input string t);
      reg_rd = 1'b1; reg_idx = 6'(idx);
      exp_q.push_back(e); tag_q.push_back(t);
      @(posedge clk); @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic pulse(input logic [10:0] m, input int n);
      for (int k = 0; k < n; k++) begin
         ev = m;
         @(posedge clk); @(negedge clk);
         ev = '0;
         @(posedge clk); @(negedge clk);
      end
   endtask

   task automatic rssi_hold(input int v, input int n);
      rssi = 11'(v);
      repeat (n) begin @(posedge clk); @(negedge clk); end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: reset values
      rd(7, 0, "R1 addr target");
      rd(9, 0, "R1 rssi threshold");
      rd(19, 0, "R1 select");
      for (int i = 26; i < 32; i++) rd(i, 0, "R1 counter");

      // R2: configuration readback, unmapped index
      wr(7, 32'hb94cb1c1);
      wr(9, 100);
      wr(19, 0);
      rd(7, 32'hb94cb1c1, "R2 addr target");
      rd(9, 100, "R2 rssi threshold");
      rd(5, 0, "R2 unmapped index");

      // R3, R5, R11 with select 0
      pulse(11'(1 << E_SPRE), 3);
      pulse(11'(1 << E_TXS), 2);
      pulse(11'(1 << E_LPRE), 2);
      pulse(11'(1 << E_TXD), 1);
      pulse(11'(1 << E_HDR), 3);
      pulse(11'((1 << E_HDR) | (1 << E_HOK)), 1);
      pulse(11'(1 << E_HOK), 2);
      pulse(11'(1 << E_GAIN), 1);

      // R6, R7 qualified frames
      sender = 32'hb94cb1c1; to_self = 1'b1; is_data = 1'b1;
      pulse(11'((1 << E_DEC) | (1 << E_CRC)), 1);
      pulse(11'(1 << E_DEC), 1);
      pulse(11'(1 << E_CRC), 1);
      to_self = 1'b0;
      pulse(11'((1 << E_DEC) | (1 << E_CRC)), 1);
      to_self = 1'b1; is_data = 1'b0;
      pulse(11'((1 << E_DEC) | (1 << E_CRC)), 1);
      is_data = 1'b1; sender = 32'hb94cb1c0;
      pulse(11'((1 << E_DEC) | (1 << E_CRC)), 1);
      sender = 32'hb94cb1c1;
      pulse(11'((1 << E_AGC) | (1 << E_ACK)), 2);

      rd(26, 3, "R3 short preamble count, R11 tx start ignored");
      rd(27, 2, "R3 long preamble count");
      rd(28, 4, "R5 header strobes");
      rd(29, 1, "R5 valid header strobes");
      rd(30, 2, "R6 qualified frames");
      rd(31, 1, "R7 crc-good qualified frames");

      // R9: clear with arbitrary data, neighbours untouched, clear wins
      wr(26, 32'hdead);
      rd(26, 0, "R9 clear");
      rd(27, 2, "R9 neighbour kept");
      ev = 11'(1 << E_HDR);
      wr(28, 32'h5);
      ev = '0;
      rd(28, 0, "R9 clear beats event");

      // R4 with select 1
      wr(19, 32'h00111111);
      rd(19, 32'h00111111, "R2 select readback");
      for (int i = 26; i < 32; i++) wr(i, 0);
      pulse(11'(1 << E_TXS), 2);
      pulse(11'(1 << E_TXD), 1);
      pulse(11'(1 << E_GAIN), 3);
      pulse(11'(1 << E_AGC), 1);
      pulse(11'(1 << E_ACK), 2);
      pulse(11'(1 << E_SPRE), 2);
      pulse(11'((1 << E_DEC) | (1 << E_CRC) | (1 << E_HDR) | (1 << E_HOK)), 1);
      rd(26, 2, "R4 tx start, R11 short preamble ignored");
      rd(27, 1, "R4 tx done");
      rd(28, 0, "R4 no rssi crossing yet, R11 header ignored");
      rd(29, 3, "R4 gain change");
      rd(30, 1, "R4 agc lock, R11 frame ignored");
      rd(31, 2, "R4 tx need ack");

      // R8: rssi crossings against threshold 100
      rssi_hold(50, 3);
      rssi_hold(150, 5);
      rssi_hold(100, 3);
      rssi_hold(101, 4);
      rssi_hold(0, 2);
      rd(28, 2, "R8 rssi crossings");

      // R10: saturation with an 8-bit counter
      wr(26, 0);
      ev = 11'(1 << E_TXS);
      repeat (300) begin @(posedge clk); @(negedge clk); end
      ev = '0;
      rd(26, 255, "R10 saturated");
      pulse(11'(1 << E_TXS), 1);
      rd(26, 255, "R10 held at max");
      wr(26, 0);
      rd(26, 0, "R9 clear after saturation");

      repeat (3) begin @(posedge clk); @(negedge clk); end
      if (exp_q.size() != 0) begin
         bad++;
         $display("FAIL R2 missing read results act=%0d exp=0", exp_q.size());
      end
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      bad++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

endmodule